// File: doc/BRIEF.md
# Wake-up Interrupt Aggregator

This block collects 28 asynchronous wake-up request lines, turns each into a sticky pending flag according to a programmable trigger condition, and folds the flags that are not masked onto four parent interrupt outputs. Each parent output covers a fixed, unequal range of lines. A handler that takes one parent interrupt therefore only has to scan the lines of that range.

Software reaches four 32-bit registers through a simple register bus. Two configuration words hold 4-bit trigger fields, and each field is shared by an adjacent pair of lines. There is also a mask word and a pending word whose bits are cleared by writing 1. Every input passes through a two-flop synchronizer. Edges are judged against the previous synchronized sample.

Top module: `wkup_irq_agg`

## Requirements
- R1: While reset is held, both configuration words read 0, the mask reads 0x0FFFFFFF (every line disabled), pending reads 0 and all four parent outputs are 0.
- R2: Register byte offsets on `bus_addr` are: 0x0 configuration for lines 0..15, 0x4 configuration for lines 16..27, 0x8 mask, 0xC pending. A write takes effect at the clock edge where `bus_en` and `bus_wr` are both high. `bus_rdata` shows the addressed register in the same cycle.
- R3: Line n uses the 4-bit field at bits 4*((n mod 16)/2)+3 down to 4*((n mod 16)/2) of word 0x0 when n<16, and of word 0x4 otherwise. Lines 2k and 2k+1 share one field. Bits 31:24 of word 0x4 read 0 and ignore writes.
- R4: Trigger codes are 0 = low level, 1 = high level, 2 = falling edge, 4 = rising edge, 6 = either edge. Any other code never sets pending.
- R5: An input change made before clock edge k is first visible in the pending register after edge k+2. Before that, the pending bit still reads its old value.
- R6: A detected event sets its pending bit whether or not the line is masked, and a masked line never drives a parent output.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. If a detection happens in the same cycle as the clear, the bit stays set.
- R8: A level-coded line whose level condition persists sets its pending bit again, so a clear does not take while the condition holds.
- R9: Parent output 0 covers lines 0..3, output 1 covers lines 4..11, output 2 covers lines 12..19 and output 3 covers lines 20..27.
- R10: A parent output is 1 exactly when some line in its range is pending and unmasked. It follows a mask or pending register change made at a clock edge with no further delay.
- R11: Bits 31:28 of the mask and pending registers read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 28 | Asynchronous wake-up request lines |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 4 | Parent interrupt outputs, one per line range |

## Verification
A wrong trigger decode or a misplaced field shows up three clock edges after the input changes, as a pending bit that is wrong when read back. A pending flag that drops without a clear, or that appears without a cause, is visible in the next pending read. A faulty range reduction puts the request on the wrong parent output as soon as the mask write lands. The bench therefore reads pending after each stimulus and watches the parent outputs across unmasking steps at the range boundaries.

// File: rtl/wkup_pkg.sv
package wkup_pkg;
   localparam int unsigned FIELD_W        = 4;
   localparam int unsigned LINES_PER_WORD = 16;

   typedef enum logic [FIELD_W-1:0] {
      TRG_LOW  = 4'd0,
      TRG_HIGH = 4'd1,
      TRG_FALL = 4'd2,
      TRG_RISE = 4'd4,
      TRG_BOTH = 4'd6
   } trig_e;
endpackage

// File: rtl/wkup_line_sync.sv
module wkup_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic last
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial assert (STAGES >= 2) else $error("wkup_line_sync: STAGES must be at least 2");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign last  = last_q;
endmodule

// File: rtl/wkup_trig_detect.sv
module wkup_trig_detect
   import wkup_pkg::*;
(
   input  logic [FIELD_W-1:0] code,
   input  logic               level,
   input  logic               last,
   output logic               hit
);
   always_comb begin
      case (code)
         TRG_LOW:  hit = ~level;
         TRG_HIGH: hit = level;
         TRG_FALL: hit = last & ~level;
         TRG_RISE: hit = ~last & level;
         TRG_BOTH: hit = last ^ level;
         default:  hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/wkup_parent_reduce.sv
module wkup_parent_reduce #(
   parameter int unsigned NUM_LINES   = 28,
   parameter int unsigned NUM_PARENTS = 4,
   parameter int unsigned FIRST_SPAN  = 4,
   parameter int unsigned SPAN        = 8
) (
   input  logic [NUM_LINES-1:0]   live,
   output logic [NUM_PARENTS-1:0] irq
);
   initial assert (NUM_LINES == FIRST_SPAN + SPAN*(NUM_PARENTS-1))
      else $error("wkup_parent_reduce: ranges do not tile the lines");

   for (genvar g = 0; g < NUM_PARENTS; g++) begin : g_par
      if (g == 0) begin : g_first
         assign irq[g] = |live[FIRST_SPAN-1:0];
      end else begin : g_rest
         localparam int unsigned LO = FIRST_SPAN + (g-1)*SPAN;
         assign irq[g] = |live[LO +: SPAN];
      end
   end
endmodule

// File: rtl/wkup_irq_agg.sv
module wkup_irq_agg
   import wkup_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 28,
   parameter int unsigned NUM_PARENTS = 4,
   parameter int unsigned FIRST_SPAN  = 4,
   parameter int unsigned SPAN        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_LINES-1:0]   line_i,
   input  logic                   bus_en,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   output logic [NUM_PARENTS-1:0] irq_o
);
   localparam int unsigned HI_LINES  = NUM_LINES - LINES_PER_WORD;
   localparam int unsigned CFG0_BITS = (LINES_PER_WORD/2)*FIELD_W;
   localparam int unsigned CFG1_BITS = (HI_LINES/2)*FIELD_W;
   localparam logic [ADDR_W-1:0] A_CFG_LO = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CFG_HI = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(8);
   localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(12);

   initial begin
      assert (CFG0_BITS == DATA_W) else $error("wkup_irq_agg: DATA_W must hold 16 fields");
      assert (NUM_LINES > LINES_PER_WORD && NUM_LINES < DATA_W)
         else $error("wkup_irq_agg: NUM_LINES out of range");
      assert (HI_LINES % 2 == 0) else $error("wkup_irq_agg: lines must pair up");
   end

   logic [CFG0_BITS-1:0] cfg_lo_q;
   logic [CFG1_BITS-1:0] cfg_hi_q;
   logic [NUM_LINES-1:0] mask_q, pend_q, hit_vec, clr_vec;
   logic                 wr_hit;

   assign wr_hit  = bus_en & bus_wr;
   assign clr_vec = (wr_hit && bus_addr == A_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

   // per-line synchronizer and trigger decode
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int unsigned POS = FIELD_W*((i % LINES_PER_WORD)/2);
      logic [FIELD_W-1:0] code;
      logic               lvl, lst;
      if (i < LINES_PER_WORD) begin : g_lo
         assign code = cfg_lo_q[POS +: FIELD_W];
      end else begin : g_hi
         assign code = cfg_hi_q[POS +: FIELD_W];
      end
      wkup_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk(clk), .rst_n(rst_n), .din(line_i[i]), .level(lvl), .last(lst));
      wkup_trig_detect i_det (
         .code(code), .level(lvl), .last(lst), .hit(hit_vec[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_lo_q <= '0;
         cfg_hi_q <= '0;
         mask_q   <= '1;
         pend_q   <= '0;
      end else begin
         if (wr_hit && bus_addr == A_CFG_LO) cfg_lo_q <= bus_wdata[CFG0_BITS-1:0];
         if (wr_hit && bus_addr == A_CFG_HI) cfg_hi_q <= bus_wdata[CFG1_BITS-1:0];
         if (wr_hit && bus_addr == A_MASK)   mask_q   <= bus_wdata[NUM_LINES-1:0];
         pend_q <= (pend_q & ~clr_vec) | hit_vec;   // set wins over clear
      end
   end

   always_comb begin
      case (bus_addr)
         A_CFG_LO: bus_rdata = DATA_W'(cfg_lo_q);
         A_CFG_HI: bus_rdata = DATA_W'(cfg_hi_q);
         A_MASK:   bus_rdata = DATA_W'(mask_q);
         A_PEND:   bus_rdata = DATA_W'(pend_q);
         default:  bus_rdata = '0;
      endcase
   end

   wkup_parent_reduce #(
      .NUM_LINES(NUM_LINES), .NUM_PARENTS(NUM_PARENTS),
      .FIRST_SPAN(FIRST_SPAN), .SPAN(SPAN)
   ) i_reduce (
      .live(pend_q & ~mask_q), .irq(irq_o));

   // ---------------- assertions ----------------
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> irq_o == '0);

   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hit && bus_addr == A_CFG_LO) |=> $stable(cfg_lo_q));

   p_pend_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit_vec)) == '0));

   p_pend_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));

   p_parent_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) == ((pend_q & ~mask_q) != '0));

   p_all_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> irq_o == '0);

   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_MASK || bus_addr == A_PEND) |-> bus_rdata[DATA_W-1:NUM_LINES] == '0);
endmodule

// File: tb/test_wkup_irq_agg.sv
`timescale 1ns/1ps
module test_wkup_irq_agg;
   localparam int unsigned NL = 28;
   localparam logic [3:0] A_CLO = 4'h0, A_CHI = 4'h4, A_MSK = 4'h8, A_PND = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NL-1:0] lines = '1;
   logic        bus_en = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_o;

   int n_chk = 0, n_err = 0;
   logic [31:0] sh_lo = '0, sh_hi = '0;
   logic [31:0] rd;

   always #2.5 clk = ~clk;

   wkup_irq_agg i_wkup_irq_agg (
      .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   // {line[4:0], code[3:0], init level, final level, expected pending}
   localparam logic [11:0] VEC [0:12] = '{
      {5'd0,  4'd4, 1'b0, 1'b1, 1'b1},
      {5'd1,  4'd4, 1'b1, 1'b0, 1'b0},
      {5'd5,  4'd2, 1'b1, 1'b0, 1'b1},
      {5'd6,  4'd2, 1'b0, 1'b1, 1'b0},
      {5'd17, 4'd6, 1'b0, 1'b1, 1'b1},
      {5'd18, 4'd6, 1'b1, 1'b0, 1'b1},
      {5'd27, 4'd1, 1'b0, 1'b1, 1'b1},
      {5'd26, 4'd1, 1'b0, 1'b0, 1'b0},
      {5'd12, 4'd0, 1'b1, 1'b0, 1'b1},
      {5'd13, 4'd0, 1'b1, 1'b1, 1'b0},
      {5'd20, 4'd3, 1'b0, 1'b1, 1'b0},
      {5'd15, 4'd5, 1'b1, 1'b0, 1'b0},
      {5'd16, 4'd4, 1'b0, 1'b1, 1'b1}};

   localparam int GRP_LINE [0:6] = '{3, 4, 11, 12, 19, 20, 27};
   localparam int GRP_IDX  [0:6] = '{0, 1, 1, 2, 2, 3, 3};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // field placement per R3
   task automatic set_code(input int ln, input logic [3:0] code);
      int pos = 4*((ln % 16)/2);
      if (ln < 16) begin
         sh_lo[pos +: 4] = code; wr(A_CLO, sh_lo);
      end else begin
         sh_hi[pos +: 4] = code; wr(A_CHI, sh_hi);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state, read while reset is still held
      repeat (3) @(negedge clk);
      rdreg(A_CLO, rd); chk("R1 cfg lo", rd, 32'h0);
      rdreg(A_CHI, rd); chk("R1 cfg hi", rd, 32'h0);
      rdreg(A_MSK, rd); chk("R1 mask", rd, 32'h0FFF_FFFF);
      rdreg(A_PND, rd); chk("R1 pend", rd, 32'h0);
      chk("R1 irq", {28'h0, irq_o}, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      settle();
      wr(A_PND, 32'hFFFF_FFFF);

      // R11 and R3: unimplemented upper bits
      wr(A_MSK, 32'hFFFF_FFFF); rdreg(A_MSK, rd); chk("R11 mask upper", rd, 32'h0FFF_FFFF);
      wr(A_PND, 32'hF000_0000); rdreg(A_PND, rd); chk("R11 pend upper", rd & 32'hF000_0000, 32'h0);
      wr(A_CHI, 32'hFFFF_FFFF); rdreg(A_CHI, rd); chk("R3 cfg hi upper", rd, 32'h00FF_FFFF);
      wr(A_CHI, 32'h0);
      wr(A_CLO, 32'hA5C3_1E69); rdreg(A_CLO, rd); chk("R2 cfg lo readback", rd, 32'hA5C3_1E69);
      wr(A_CLO, 32'h0);

      // table: R3 placement, R4 trigger codes, R6 masked latch
      for (int v = 0; v < 13; v++) begin
         automatic int ln = int'(VEC[v][11:7]);
         set_code(ln, VEC[v][6:3]);
         lines[ln] = VEC[v][2];
         settle();
         wr(A_PND, 32'h1 << ln);
         @(negedge clk) lines[ln] = VEC[v][1];
         settle();
         rdreg(A_PND, rd);
         chk($sformatf("R4 line %0d code %0d", ln, VEC[v][6:3]), {31'h0, rd[ln]}, {31'h0, VEC[v][0]});
         chk("R6 masked irq quiet", {28'h0, irq_o}, 32'h0);
      end

      // R5: latency of a rising edge on line 3
      set_code(3, 4'd4);
      lines[3] = 1'b0; settle(); wr(A_PND, 32'h8);
      @(negedge clk) begin lines[3] = 1'b1; bus_addr = A_PND; end
      @(negedge clk); @(negedge clk);
      #1 chk("R5 not yet after two edges", {31'h0, bus_rdata[3]}, 32'h0);
      @(negedge clk);
      #1 chk("R5 set after third edge", {31'h0, bus_rdata[3]}, 32'h1);

      // R9/R10: parent ranges at their boundaries; R7 clear semantics
      for (int k = 0; k < 7; k++) begin
         automatic int ln = GRP_LINE[k];
         set_code(ln, 4'd4);
         lines[ln] = 1'b0; settle();
         wr(A_PND, 32'hFFFF_FFFF);
         @(negedge clk) lines[ln] = 1'b1;
         settle();
         rdreg(A_PND, rd); chk("R6 pending while masked", {31'h0, rd[ln]}, 32'h1);
         chk("R6 masked irq", {28'h0, irq_o}, 32'h0);
         wr(A_MSK, ~(32'h1 << ln) & 32'h0FFF_FFFF);
         #1 chk($sformatf("R9 R10 line %0d parent", ln), {28'h0, irq_o}, 32'h1 << GRP_IDX[k]);
         wr(A_PND, 32'h0);
         rdreg(A_PND, rd); chk("R7 write zero keeps", {31'h0, rd[ln]}, 32'h1);
         wr(A_PND, 32'h1 << ln);
         rdreg(A_PND, rd); chk("R7 write one clears", {31'h0, rd[ln]}, 32'h0);
         #1 chk("R10 irq drops after clear", {28'h0, irq_o}, 32'h0);
         wr(A_MSK, 32'h0FFF_FFFF);
      end

      // R8: persisting level re-sets pending; R7 set wins over clear
      set_code(9, 4'd1);
      lines[9] = 1'b1; settle();
      wr(A_PND, 32'h200);
      rdreg(A_PND, rd); chk("R8 level holds pending", {31'h0, rd[9]}, 32'h1);
      lines[9] = 1'b0; settle();
      wr(A_PND, 32'h200);
      rdreg(A_PND, rd); chk("R8 clear after level ends", {31'h0, rd[9]}, 32'h0);

      finish_run();
   end
endmodule